// File: doc/BRIEF.md
# Transmit Packet FIFO with Skid-Tolerant Ready

This block buffers transmit packet words between a user application and a line-side consumer. Everything runs on one clock. Each write carries a 64-bit data word, a start-of-packet flag, an end-of-packet flag and a 3-bit count of valid bytes for the final word. A packet may end partway through a word. The read side presents the oldest stored word, its flags and its byte count as soon as the word is stored (first-word fall-through). A word leaves the FIFO when valid and ready are both high.

The write-side ready is an almost-full flag, not a not-full flag. It drops once the number of free entries falls to a run-time threshold or below. That leaves room for a burst of writes that the application issues before it sees the flag drop. With the threshold set to at least the skid count, a writer that stops within the skid window never loses a word. A write that still finds every entry occupied is discarded, and a sticky flag records it.

Top module: `tx_pkt_fifo`

## Requirements
- R1: While reset is low and right after it is released, the FIFO is empty: `rd_valid` is 0, `overflow` is 0 and `wr_ready` is 1 (for any threshold below the depth).
- R2: `wr_ready` is 1 exactly when the free entries (DEPTH minus the stored words) are more than `af_thresh`. It follows the current occupancy and threshold in the same cycle.
- R3: With `af_thresh` at least SKID (8), a writer that issues at most 8 writes after `wr_ready` goes low has every word stored and never raises `overflow`.
- R4: Words come out in the order they were accepted. Data, start flag, end flag and byte count come out unchanged. `wr_data[7:0]` is byte 0, the first byte on the line. A byte count of 0 means all 8 bytes are valid, and k in 1 to 7 means bytes 0 to k-1 are valid.
- R5: `rd_valid` is 1 exactly when at least one word is stored. The oldest word is on the read outputs in the cycle after it is written into an empty FIFO. A word is removed only on a cycle where `rd_valid` and `rd_ready` are both 1.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, the read outputs hold their values.
- R7: A write to a full FIFO with no removal in the same cycle is discarded: the stored words are unchanged. `overflow` then goes to 1 and stays 1 until reset.
- R8: A write to a full FIFO in the same cycle as a removal is stored, and `overflow` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| af_thresh | input | 6 | Almost-full threshold in free entries (at least 8) |
| wr_valid | input | 1 | Write request |
| wr_data | input | 64 | Write data word, byte 0 in bits 7:0 |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_mod | input | 3 | Valid bytes in the final word (0 = all 8) |
| wr_ready | output | 1 | Almost-full ready to the writer |
| overflow | output | 1 | Sticky flag: a write was dropped |
| rd_valid | output | 1 | A word is presented |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_data | output | 64 | Presented data word |
| rd_sop | output | 1 | Presented word starts a packet |
| rd_eop | output | 1 | Presented word ends a packet |
| rd_mod | output | 3 | Presented byte count |

## Verification
A write and a removal can happen in the same cycle. This matters most at full occupancy, where the removal is what makes room for the write. The random phase holds the consumer ready on most cycles while the writer is active, which gives many cycles with both a write and a removal. A directed case fills all 32 entries and then writes and removes together. A queue model in the bench decides whether each write is stored. It is compared with every word that comes out and with the overflow flag, which must stay low.

// File: rtl/tx_fifo_pkg.sv
// Package: default sizes and occupancy helper shared by the transmit FIFO.
// Assumes the depth fits in the occupancy counter width the top derives.
package tx_fifo_pkg;

    localparam int unsigned TX_DATA_W = 64;
    localparam int unsigned TX_MOD_W  = 3;
    localparam int unsigned TX_DEPTH  = 32;
    localparam int unsigned TX_SKID   = 8;

    // Free entries left given the depth and the stored word count.
    function automatic int unsigned free_slots(input int unsigned depth, input int unsigned used);
        return depth - used;
    endfunction

endpackage

// File: rtl/tx_fifo_mem.sv
// Storage array: one write port, one combinational read port.
// Assumes the controller never writes and reads past occupancy.
module tx_fifo_mem #(
    parameter int unsigned WIDTH = 69,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // Capture an accepted word at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Present the head entry without latency (fall-through).
    assign rdata = store[raddr];

endmodule

// File: rtl/tx_fifo_ctrl.sv
// Pointer and occupancy control: decides push, pop and drop each cycle.
// A write to a full FIFO is taken only if a pop frees an entry the same cycle.
module tx_fifo_ctrl #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          rd_ready,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] used,
    output logic          not_empty,
    output logic          dropped
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic full;
    logic pop;
    logic drop_now;

    // Derive this cycle's transfer decisions from occupancy.
    always_comb begin
        full      = (used == FULL_CNT);
        not_empty = (used != '0);
        pop       = rd_ready && not_empty;
        push      = wr_valid && (!full || pop);
        drop_now  = wr_valid && full && !pop;
    end

    // Advance the write pointer on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr <= '0;
        end else if (push) begin
            waddr <= (waddr == LAST_IDX) ? '0 : waddr + 1'b1;
        end
    end

    // Advance the read pointer on every removed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr <= '0;
        end else if (pop) begin
            raddr <= (raddr == LAST_IDX) ? '0 : raddr + 1'b1;
        end
    end

    // Track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else begin
            case ({push, pop})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

    // Hold the overflow record until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropped <= 1'b0;
        end else if (drop_now) begin
            dropped <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_fifo_afull.sv
// Almost-full ready: high while free entries exceed the threshold.
// Assumes the threshold is at least the writer's skid length.
module tx_fifo_afull #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] used,
    input  logic [CW-1:0] thresh,
    output logic          ready
);

    logic [CW-1:0] free_cnt;

    // Compare the remaining room with the programmed margin.
    always_comb begin
        free_cnt = CW'(tx_fifo_pkg::free_slots(DEPTH, int'(used)));
        ready    = (free_cnt > thresh);
    end

endmodule

// File: rtl/tx_pkt_fifo.sv
// Transmit packet FIFO with an almost-full ready that tolerates a write skid.
// Single clock, synchronous active-low reset, first-word fall-through read.
// Assumes af_thresh >= SKID so the writer may continue SKID writes after ready drops.
module tx_pkt_fifo #(
    parameter int unsigned DATA_W = tx_fifo_pkg::TX_DATA_W,
    parameter int unsigned MOD_W  = tx_fifo_pkg::TX_MOD_W,
    parameter int unsigned DEPTH  = tx_fifo_pkg::TX_DEPTH,
    parameter int unsigned SKID   = tx_fifo_pkg::TX_SKID,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned ENT_W = DATA_W + MOD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     af_thresh,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [MOD_W-1:0]  wr_mod,
    output logic              wr_ready,
    output logic              overflow,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic [MOD_W-1:0]  rd_mod
);

    logic             push;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic [CW-1:0]    used;
    logic [ENT_W-1:0] wr_ent;
    logic [ENT_W-1:0] rd_ent;

    // Pack the write-side fields into one storage entry.
    assign wr_ent = {wr_sop, wr_eop, wr_mod, wr_data};

    tx_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .rd_ready  (rd_ready),
        .push      (push),
        .waddr     (waddr),
        .raddr     (raddr),
        .used      (used),
        .not_empty (rd_valid),
        .dropped   (overflow)
    );

    tx_fifo_mem #(.WIDTH(ENT_W), .DEPTH(DEPTH)) i_mem (
        .clk   (clk),
        .we    (push),
        .waddr (waddr),
        .wdata (wr_ent),
        .raddr (raddr),
        .rdata (rd_ent)
    );

    tx_fifo_afull #(.DEPTH(DEPTH)) i_afull (
        .used   (used),
        .thresh (af_thresh),
        .ready  (wr_ready)
    );

    // Unpack the head entry onto the read-side fields.
    assign {rd_sop, rd_eop, rd_mod, rd_data} = rd_ent;

endmodule

// File: rtl/tx_pkt_fifo_chk.sv
// Checker for tx_pkt_fifo, observing its ports only; bound below.
// Counts writes made while ready is low to judge the skid window.
module tx_pkt_fifo_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned MOD_W  = 3,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned SKID   = 8,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned SW    = $clog2(SKID + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     af_thresh,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              overflow,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_sop,
    input logic              rd_eop,
    input logic [MOD_W-1:0]  rd_mod
);

    localparam logic [SW-1:0] SKID_LIM = SW'(SKID);

    logic [SW-1:0] skid_cnt;

    // Count writes issued since ready was last seen high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || wr_ready) begin
            skid_cnt <= '0;
        end else if (wr_valid && skid_cnt != SKID_LIM) begin
            skid_cnt <= skid_cnt + 1'b1;
        end
    end

    // R3: the threshold must leave room for the skid.
    p_thresh_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        af_thresh >= CW'(SKID));

    // R3: writes inside the skid window never cause a drop.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_ready || skid_cnt < SKID_LIM)) |=> !$rose(overflow));

    // R7: overflow stays set once raised.
    p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R5: a write into an empty FIFO is presented next cycle.
    p_fall_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !rd_valid) |=> rd_valid);

    // R6: a stalled head word holds still.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_sop)
                                     && $stable(rd_eop) && $stable(rd_mod)));

endmodule

bind tx_pkt_fifo tx_pkt_fifo_chk #(
    .DATA_W(DATA_W), .MOD_W(MOD_W), .DEPTH(DEPTH), .SKID(SKID)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .af_thresh (af_thresh),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .overflow  (overflow),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_sop    (rd_sop),
    .rd_eop    (rd_eop),
    .rd_mod    (rd_mod)
);

// File: tb/test_tx_pkt_fifo.sv
// Bench for tx_pkt_fifo: directed corners plus seeded random traffic, checked
// against a queue model kept in the bench.
module test_tx_pkt_fifo;

    localparam int DEPTH = 32;
    localparam int SKID  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  af_thresh = 6'd8;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_sop = 1'b0;
    logic        wr_eop = 1'b0;
    logic [2:0]  wr_mod = '0;
    logic        wr_ready;
    logic        overflow;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [63:0] rd_data;
    logic        rd_sop;
    logic        rd_eop;
    logic [2:0]  rd_mod;

    logic [68:0] model_q[$];
    bit          ovf_m;
    int          checks;
    int          errors;
    bit          finished;
    int          wseq;

    always #4 clk = ~clk;

    tx_pkt_fifo i_tx_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .af_thresh(af_thresh),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_mod(wr_mod), .wr_ready(wr_ready), .overflow(overflow),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_mod(rd_mod)
    );

    task automatic chk(input bit ok, input string req, input logic [68:0] act, input logic [68:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Word n of a stream of 5-word packets; the last word carries a partial byte count (R4).
    function automatic logic [68:0] make_word(input int n);
        logic sop;
        logic eop;
        logic [2:0] md;
        sop = (n % 5 == 0);
        eop = (n % 5 == 4);
        md  = eop ? 3'(n % 8) : 3'd0;
        return {sop, eop, md, {32'(n), 32'hA5C3_0000 ^ 32'(n * 7)}};
    endfunction

    // One clock: drive at the falling edge, check outputs, update the model at the rising edge.
    task automatic cycle(input bit wv, input logic [68:0] w, input bit rr);
        int sz;
        bit acc;
        bit pop;
        @(negedge clk);
        wr_valid = wv;
        {wr_sop, wr_eop, wr_mod, wr_data} = w;
        rd_ready = rr;
        #1;
        sz = model_q.size();
        chk(wr_ready == ((DEPTH - sz) > int'(af_thresh)), "R2 ready", 69'(wr_ready), 69'((DEPTH - sz) > int'(af_thresh)));
        chk(rd_valid == (sz > 0), "R5 valid", 69'(rd_valid), 69'(sz > 0));
        if (sz > 0) begin
            chk({rd_sop, rd_eop, rd_mod, rd_data} == model_q[0], "R4 order",
                {rd_sop, rd_eop, rd_mod, rd_data}, model_q[0]);
        end
        pop = rr && (sz > 0);
        acc = wv && ((sz < DEPTH) || pop);
        if (wv && !acc) ovf_m = 1'b1;
        @(posedge clk);
        if (pop) void'(model_q.pop_front());
        if (acc) model_q.push_back(w);
        #1;
        chk(overflow == ovf_m, "R7 overflow", 69'(overflow), 69'(ovf_m));
    endtask

    task automatic do_reset(input logic [5:0] th);
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0;
        rd_ready = 1'b0;
        af_thresh = th;
        repeat (3) @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", 69'(rd_valid), 69'd0);
        rst_n = 1'b1;
        model_q.delete();
        ovf_m = 1'b0;
        @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R1 rd_valid", 69'(rd_valid), 69'd0);
        chk(overflow == 1'b0, "R1 overflow", 69'(overflow), 69'd0);
        chk(wr_ready == 1'b1, "R1 wr_ready", 69'(wr_ready), 69'd1);
    endtask

    task automatic write_one(input bit rr);
        cycle(1'b1, make_word(wseq), rr);
        wseq++;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (model_q.size() > 0 && guard < 200) begin
            cycle(1'b0, '0, 1'b1);
            guard++;
        end
        chk(model_q.size() == 0, "R5 drain", 69'(model_q.size()), 69'd0);
    endtask

    initial begin
        logic [68:0] held;
        int skid;
        checks = 0;
        errors = 0;
        wseq = 0;
        ovf_m = 1'b0;

        // R1 and R2/R3/R7 at threshold 8: fill until ready drops, then the skid.
        do_reset(6'd8);
        for (int i = 0; i < DEPTH - SKID; i++) write_one(1'b0);
        #1;
        chk(wr_ready == 1'b0, "R2 ready low at free==thresh", 69'(wr_ready), 69'd0);
        for (int i = 0; i < SKID; i++) begin
            write_one(1'b0);
            chk(overflow == 1'b0, "R3 skid write kept", 69'(overflow), 69'd0);
        end
        chk(model_q.size() == DEPTH, "R3 all skid words stored", 69'(model_q.size()), 69'(DEPTH));
        write_one(1'b0);
        chk(overflow == 1'b1, "R7 drop sets overflow", 69'(overflow), 69'd1);
        // R6: stall the consumer and watch the head hold.
        held = {rd_sop, rd_eop, rd_mod, rd_data};
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, '0, 1'b0);
            chk({rd_sop, rd_eop, rd_mod, rd_data} == held, "R6 hold", {rd_sop, rd_eop, rd_mod, rd_data}, held);
        end
        drain();
        chk(overflow == 1'b1, "R7 overflow sticky", 69'(overflow), 69'd1);

        // R8: write and remove together at full occupancy.
        do_reset(6'd8);
        for (int i = 0; i < DEPTH; i++) write_one(1'b0);
        write_one(1'b1);
        chk(overflow == 1'b0, "R8 write with pop at full kept", 69'(overflow), 69'd0);
        chk(model_q.size() == DEPTH, "R8 occupancy stays full", 69'(model_q.size()), 69'(DEPTH));
        drain();

        // R2 at threshold 12: ready toggles around 12 free entries.
        do_reset(6'd12);
        for (int i = 0; i < DEPTH - 12; i++) write_one(1'b0);
        #1;
        chk(wr_ready == 1'b0, "R2 ready low at thresh 12", 69'(wr_ready), 69'd0);
        cycle(1'b0, '0, 1'b1);
        #1;
        chk(wr_ready == 1'b1, "R2 ready back after one read", 69'(wr_ready), 69'd1);
        drain();

        // Random traffic, writer obeys ready plus the skid; R3 and R4 judged by the model.
        do_reset(6'd8);
        void'($urandom(32'd4242));
        skid = 0;
        for (int n = 0; n < 4000; n++) begin
            bit wv;
            bit rr;
            if (n % 500 == 499) af_thresh = 6'(8 + ($urandom % 13));
            #0;
            if (wr_ready) skid = 0;
            wv = (($urandom % 100) < 70) && (wr_ready || skid < SKID);
            rr = (($urandom % 100) < 55);
            if (wv && !wr_ready) skid++;
            if (wv) begin
                cycle(1'b1, make_word(wseq), rr);
                wseq++;
            end else begin
                cycle(1'b0, '0, rr);
            end
        end
        chk(overflow == 1'b0, "R3 no drop under skid-bounded random writes", 69'(overflow), 69'd0);
        drain();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule